// File: doc/BRIEF.md
# Pipelined Carry-In Incrementer

This block adds a single carry-in bit to a WIDTH-bit operand through a chain of registered half-adder cells. Each pipeline stage resolves GROUP bits of the ripple and registers everything at its output. The bits already summed and the operand bits still waiting move down alongside the carry in plain registers. The block therefore takes a new operand on every clock cycle and returns each result a fixed number of cycles later.

A one-bit valid flag travels through a shadow pipeline of the same depth. The output flag rises in exactly the cycle in which the matching result appears. A synchronous active-low clear empties the whole pipeline. With GROUP set to 1 the latency equals WIDTH. A larger GROUP, which must divide WIDTH, gives a latency of WIDTH/GROUP and a longer combinational carry chain in each stage.

Top module: `pipe_incrementer`

## Requirements
- R1: For an operand A and carry-in c presented in one cycle, {carry_out, sum} later equals A + c as a (WIDTH+1)-bit unsigned sum.
- R2: The result of an input sampled at a clock edge appears on the outputs after WIDTH/GROUP - 1 further edges, i.e. WIDTH/GROUP cycles after it was presented.
- R3: out_valid repeats in_valid with the same latency as the data, and back-to-back inputs produce back-to-back results with no bubbles.
- R4: When rst_n is low at a clock edge, every pipeline register is cleared at that edge. Outputs that would have carried in-flight data read out_valid=0, sum=0, carry_out=0 instead.
- R5: An all-ones operand with carry_in=1 wraps around to sum=0 and carry_out=1. carry_out is never 1 with a non-zero sum.
- R6: With carry_in=0 the sum equals the operand and carry_out is 0.
- R7: With GROUP=3 and WIDTH=6 the latency drops to 2 cycles and the results still satisfy R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all pipeline registers |
| rst_n | input | 1 | Synchronous active-low clear of data and valid registers |
| in_valid | input | 1 | Marks the current operand as meaningful |
| operand | input | WIDTH | Value to be incremented |
| carry_in | input | 1 | Bit added to the operand |
| out_valid | output | 1 | Marks the current sum as the result of a valid input |
| sum | output | WIDTH | Low WIDTH bits of operand + carry_in |
| carry_out | output | 1 | Overflow bit of operand + carry_in |

## Verification
Every operand of a 6-bit configuration is streamed back to back with both carry-in values. This separates a correct ripple from one that drops or misroutes a carry at any bit position, including the full wrap from all ones. A stretch with the valid flag low but data still moving shows that data and valid flow independently. A clear pulse in the middle of a burst checks that in-flight results are discarded, not merely delayed. The same stimulus is run through a grouped 2-stage instance, which checks the shorter latency against the same arithmetic.

// File: rtl/incr_pipe_pkg.sv
// Shared helpers for the pipelined incrementer.
// Assumes GROUP divides WIDTH; a zero GROUP is treated as one bit per stage.
package incr_pipe_pkg;

    // Number of registered stages for a given width and bits-per-stage.
    function automatic int unsigned stage_count(input int unsigned width,
                                                input int unsigned group);
        return (group == 0) ? width : width / group;
    endfunction

endpackage

// File: rtl/incr_stage.sv
// One registered stage of the incrementer grid.
// Wire positions 0..WIDTH: positions below BASE hold finished sum bits,
// position BASE holds the running carry, and positions above it hold operand
// bits not yet used. The stage resolves GROUP bits and registers every position.
// Assumes BASE + GROUP <= WIDTH.
module incr_stage #(
    parameter int WIDTH     = 8,
    parameter int GROUP     = 1,
    parameter int STAGE_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH:0]   w_in,
    output logic [WIDTH:0]   w_out
);
    localparam int BASE = STAGE_IDX * GROUP;

    logic [WIDTH:0] nxt;
    logic           c;
    logic           a;

    // Half-adder chain over this stage's bits; other positions pass unchanged.
    always_comb begin
        nxt = w_in;
        c   = w_in[BASE];
        a   = 1'b0;
        for (int j = 0; j < GROUP; j++) begin
            a             = w_in[BASE + j + 1];
            nxt[BASE + j] = c ^ a;
            c             = c & a;
        end
        nxt[BASE + GROUP] = c;
    end

    // Stage register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) w_out <= '0;
        else        w_out <= nxt;
    end

endmodule

// File: rtl/incr_valid_pipe.sv
// Valid shadow pipeline: delays a one-bit flag by DEPTH registered cycles.
// Assumes DEPTH >= 1.
module incr_valid_pipe #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);
    logic [DEPTH-1:0] sr;

    generate
        if (DEPTH == 1) begin : g_single
            // Single flag register.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= vin;
            end
        end else begin : g_chain
            // Shift register, newest flag at bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[DEPTH-2:0], vin};
            end
        end
    endgenerate

    assign vout = sr[DEPTH-1];

endmodule

// File: rtl/pipe_incrementer.sv
// Fully pipelined incrementer: operand + carry_in through WIDTH/GROUP
// registered half-adder stages, one new input per cycle, with a valid shadow.
// Assumes GROUP divides WIDTH. The clear is synchronous and active low.
module pipe_incrementer
    import incr_pipe_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int GROUP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] operand,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int STAGES = int'(stage_count(WIDTH, GROUP));

    logic [STAGES:0][WIDTH:0] grid;

    // Row 0: carry at position 0, operand bits above it, LSB first.
    assign grid[0] = {operand, carry_in};

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            incr_stage #(
                .WIDTH    (WIDTH),
                .GROUP    (GROUP),
                .STAGE_IDX(s)
            ) u_stage (
                .clk  (clk),
                .rst_n(rst_n),
                .w_in (grid[s]),
                .w_out(grid[s+1])
            );
        end
    endgenerate

    incr_valid_pipe #(.DEPTH(STAGES)) u_valid (
        .clk  (clk),
        .rst_n(rst_n),
        .vin  (in_valid),
        .vout (out_valid)
    );

    assign sum       = grid[STAGES][WIDTH-1:0];
    assign carry_out = grid[STAGES][WIDTH];

endmodule

// File: rtl/pipe_incrementer_chk.sv
// Checker for pipe_incrementer: keeps an arithmetic reference pipeline and
// compares the block's outputs against it every cycle.
module pipe_incrementer_chk
    import incr_pipe_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int GROUP = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] operand,
    input logic             carry_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out
);
    localparam int STAGES = int'(stage_count(WIDTH, GROUP));

    logic [STAGES-1:0][WIDTH:0] mdl_d;
    logic [STAGES-1:0]          mdl_v;

    // Reference delay line of arithmetic results and valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdl_d <= '0;
            mdl_v <= '0;
        end else begin
            mdl_d[0] <= (WIDTH+1)'(operand) + (WIDTH+1)'(carry_in);
            mdl_v[0] <= in_valid;
            for (int s = 1; s < STAGES; s++) begin
                mdl_d[s] <= mdl_d[s-1];
                mdl_v[s] <= mdl_v[s-1];
            end
        end
    end

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && sum == '0 && !carry_out));

    // R3
    valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == mdl_v[STAGES-1]);

    // R1 R2
    sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {carry_out, sum} == mdl_d[STAGES-1]);

    // R5
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (sum == '0));

endmodule

bind pipe_incrementer pipe_incrementer_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (.*);

// File: tb/tb_pipe_incrementer.sv
// Bench: streams every 6-bit operand with both carry-in values through a
// 1-bit-per-stage instance and a 3-bit-per-stage instance, and checks each
// output cycle against arithmetic computed here.
module tb_pipe_incrementer;
    localparam int W          = 6;
    localparam int CLK_PERIOD = 10;
    localparam int L1         = 6;
    localparam int L2         = 2;
    localparam int HN         = 256;
    localparam int LAST       = 180;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         carry_in;
    logic [W-1:0] operand;
    logic         ov1, co1, ov2, co2;
    logic [W-1:0] s1, s2;

    logic         h_rst [HN];
    logic         h_v   [HN];
    logic         h_c   [HN];
    logic [W-1:0] h_a   [HN];

    int edges = 0;
    int n_cmp = 0;
    int n_bad = 0;

    pipe_incrementer #(.WIDTH(W), .GROUP(1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .carry_in(carry_in), .out_valid(ov1), .sum(s1), .carry_out(co1)
    );

    pipe_incrementer #(.WIDTH(W), .GROUP(3)) dut_g3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .carry_in(carry_in), .out_valid(ov2), .sum(s2), .carry_out(co2)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) edges <= edges + 1;

    // Compare one instance's outputs after edge k with the input sampled
    // lat-1 edges earlier, or with zeros if a clear fell inside that window.
    task automatic check_dut(input int lat, input int k, input logic ov,
                             input logic [W-1:0] s, input logic co);
        bit           in_rst = 1'b0;
        logic         ev;
        logic [W:0]   ed;
        logic [W:0]   got;
        int           src;
        string        tv;
        string        td;
        for (int m = k - lat + 1; m <= k; m++)
            if (m >= 1 && !h_rst[m]) in_rst = 1'b1;
        src = k - lat + 1;
        if (in_rst || src < 1) begin
            ev = 1'b0;
            ed = '0;
            tv = "R4";
            td = "R4";
        end else begin
            ev = h_v[src];
            ed = {1'b0, h_a[src]} + {{W{1'b0}}, h_c[src]};
            if (lat == L2) begin
                tv = "R7";
                td = "R7";
            end else begin
                tv = "R3";
                if (h_a[src] == {W{1'b1}} && h_c[src]) td = "R5";
                else if (!h_c[src])                    td = "R6";
                else                                   td = "R1 R2";
            end
        end
        got = {co, s};
        n_cmp++;
        if (ov !== ev) begin
            n_bad++;
            $display("FAIL %s out_valid (lat %0d, edge %0d): got %0b expected %0b",
                     tv, lat, k, ov, ev);
        end
        n_cmp++;
        if (got !== ed) begin
            n_bad++;
            $display("FAIL %s {carry_out,sum} (lat %0d, edge %0d): got %0h expected %0h",
                     td, lat, k, got, ed);
        end
    endtask

    // Drive the inputs that will be sampled at edge t, and record them.
    task automatic drive(input int t);
        logic         r = 1'b1;
        logic         v = 1'b0;
        logic         c = 1'b0;
        logic [W-1:0] a = '0;
        int           idx;
        if (t <= 4) begin
            r = 1'b0;                                  // initial clear, R4
        end else if (t <= 132) begin
            idx = t - 5;                               // exhaustive sweep, R1 R5 R6
            v = 1'b1;
            a = W'(idx);
            c = idx[6];
        end else if (t <= 140) begin
            a = W'(t * 7);                             // data flowing with valid low, R3
            c = t[0];
        end else if (t <= 150) begin
            v = 1'b1;
            a = W'(t * 13);
            c = 1'b1;
        end else if (t == 151) begin
            r = 1'b0;                                  // mid-burst clear, R4
            v = 1'b1;
            a = '1;
            c = 1'b1;
        end else if (t <= 160) begin
            v = 1'b1;
            a = '1;
            c = t[0];
        end
        rst_n    = r;
        in_valid = v;
        carry_in = c;
        operand  = a;
        h_rst[t] = r;
        h_v[t]   = v;
        h_c[t]   = c;
        h_a[t]   = a;
    endtask

    initial begin
        for (int i = 0; i < HN; i++) begin
            h_rst[i] = 1'b1;
            h_v[i]   = 1'b0;
            h_c[i]   = 1'b0;
            h_a[i]   = '0;
        end
        drive(1);
        for (int it = 0; it < LAST; it++) begin
            @(negedge clk);
            check_dut(L1, edges, ov1, s1, co1);
            check_dut(L2, edges, ov2, s2, co2);
            drive(edges + 1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 5000);
        n_cmp++;
        n_bad++;
        $display("FAIL R3 watchdog: got no completion expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule